// File: doc/BRIEF.md
# Cumulative Throttle-Time Monitor

This block tracks how long an active-low throttle input has been held asserted, summed over any number of separate assertions. The total is kept in an unsigned accumulator. Each unit represents one period of an external time-base tick, nominally 25 ms, so the default 8-bit width spans about 6.4 s. The first assertion seen on an empty accumulator counts as one unit at once. After that, every tick that arrives while the input is low adds one more unit. The throttle pin is asynchronous and passes through a flop synchroniser before any decision is made.

A host reads the accumulator through a read strobe. The value is visible during the strobe cycle and the read clears it. If the input is still low at the time of the read, the accumulator restarts at one. A separate comparator checks the accumulator against a programmable limit. When the count exceeds the limit, a sticky status flag is latched and an active-low alert is driven. A mask input can hold the alert high without affecting the flag. The flag clears on a timer read, or on a status read once the count no longer exceeds the limit.

There are two state machines. The edge tracker has the states PH_IDLE (synchronised input high) and PH_LOW (synchronised input low). It moves PH_IDLE→PH_LOW when the synchronised input falls, and this transition is the assertion edge. It moves PH_LOW→PH_IDLE when the input rises. The flag machine has the states FL_CLEAR and FL_SET. It moves FL_CLEAR→FL_SET when the count exceeds the limit and no timer read is present. It moves FL_SET→FL_CLEAR on a timer read, or on a status read while the count is at or below the limit.

Top module: `tmon_top`

## Requirements
- R1: After reset, `timer_q` is 0, `status` is 0 and `alert_n` is 1.
- R2: The throttle pin passes through two flops. If the accumulator is 0 when a falling edge of the synchronised input is seen, the accumulator becomes 1 on the third rising clock edge after the pin falls. An edge seen while the accumulator is nonzero adds nothing.
- R3: Each cycle with `tick`=1 while the synchronised input is low adds one to the accumulator. Ticks while it is high are ignored. For example, one first-edge unit plus four low ticks reads 5 (binary 00000101).
- R4: A `rd_timer` strobe while the synchronised input is high shows the old value on `timer_q` during the strobe cycle. The next cycle `timer_q` is 0 and `status` is 0.
- R5: A `rd_timer` strobe while the synchronised input is low makes `timer_q` 1 in the next cycle, and later low ticks count up from 1.
- R6: The accumulator saturates at all ones (0xFF by default) and never wraps.
- R7: One cycle after `timer_q` > `limit` (unsigned) with no timer read, `status` is 1. With `limit`=0 the first assertion trips it. With `limit`=1 a count of 1 does not trip it and a count of 2 does.
- R8: `alert_n` is registered. It is 0 exactly when the flag is set and `mask` was 0 at the same clock edge. With `mask`=1 the flag still sets but `alert_n` stays 1.
- R9: `status` is sticky. A `rd_status` strobe clears it only if `timer_q` <= `limit` in that cycle. Otherwise it stays 1.
- R10: If `rd_timer` is strobed during an assertion with `limit`=0, `status` is 0 for one cycle and then is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throttle_n | input | 1 | Asynchronous active-low throttle input |
| tick | input | 1 | One-cycle time-base pulse, one accumulator unit |
| limit | input | CNT_W | Comparison limit |
| mask | input | 1 | 1 holds the alert inactive |
| rd_timer | input | 1 | Timer read strobe (clear on read) |
| rd_status | input | 1 | Status read strobe |
| timer_q | output | CNT_W | Accumulator value |
| status | output | 1 | Sticky limit-exceeded flag |
| alert_n | output | 1 | Active-low alert |

## Verification
If the edge tracker sits in the wrong state, the accumulator either misses its first unit or adds an extra one. This appears on `timer_q` two to three cycles after the pin moves. A wrong accumulator value reaches `timer_q` in the same cycle and reaches `status` one cycle later through the comparator. A flag machine stuck in either state shows on `status` and `alert_n` at the next read strobe or the next time the limit is crossed. The bench models the two-flop delay, the clear-on-read reload and the flag priorities, and compares all three outputs every cycle.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int unsigned DEF_CNT_W = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    typedef enum logic {
        FL_CLEAR = 1'b0,
        FL_SET   = 1'b1
    } flag_e;
endpackage

// File: rtl/tmon_sync.sv
module tmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tmon_accum.sv
module tmon_accum
    import tmon_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_low,
    input  logic             tick,
    input  logic             rd_timer,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             first_edge;

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (pin_low)  phase_d = PH_LOW;
            PH_LOW:  if (!pin_low) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    assign first_edge = (phase_q == PH_IDLE) && pin_low;

    // Accumulator next value: read reload beats first-edge unit beats tick
    always_comb begin
        count_d = count_q;
        if (rd_timer) begin
            count_d = pin_low ? CNT_ONE : '0;
        end else if (first_edge && (count_q == '0)) begin
            count_d = CNT_ONE;
        end else if (tick && pin_low && (count_q != CNT_MAX)) begin
            count_d = count_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !rd_timer) |=> (count_q == CNT_MAX));

    p_read_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_timer |=> (count_q <= CNT_ONE));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_timer |=> (({1'b0, count_q} <= ({1'b0, $past(count_q)} + 1'b1))
                       && (count_q >= $past(count_q))));
endmodule

// File: rtl/tmon_flag.sv
module tmon_flag
    import tmon_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    input  logic             mask,
    input  logic             rd_timer,
    input  logic             rd_status,
    output logic             status,
    output logic             alert_n
);
    flag_e flag_q, flag_d;
    logic  over;
    logic  alert_n_q;

    assign over = (count > limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= FL_CLEAR;
        else        flag_q <= flag_d;
    end

    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FL_CLEAR: if (over && !rd_timer) flag_d = FL_SET;
            FL_SET: begin
                if (rd_timer)                flag_d = FL_CLEAR;
                else if (rd_status && !over) flag_d = FL_CLEAR;
            end
            default: flag_d = FL_CLEAR;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alert_n_q <= 1'b1;
        else        alert_n_q <= !((flag_d == FL_SET) && !mask);
    end

    assign status  = (flag_q == FL_SET);
    assign alert_n = alert_n_q;

    p_over_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (over && !rd_timer) |=> status);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !rd_timer && !rd_status) |=> status);

    p_timer_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_timer |=> !status);
endmodule

// File: rtl/tmon_top.sv
module tmon_top
    import tmon_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             throttle_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             mask,
    input  logic             rd_timer,
    input  logic             rd_status,
    output logic [CNT_W-1:0] timer_q,
    output logic             status,
    output logic             alert_n
);
    logic pin_sync;
    logic pin_low;

    tmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (throttle_n),
        .dout  (pin_sync)
    );

    assign pin_low = !pin_sync;

    tmon_accum #(.CNT_W(CNT_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_low  (pin_low),
        .tick     (tick),
        .rd_timer (rd_timer),
        .count    (timer_q)
    );

    tmon_flag #(.CNT_W(CNT_W)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (timer_q),
        .limit     (limit),
        .mask      (mask),
        .rd_timer  (rd_timer),
        .rd_status (rd_status),
        .status    (status),
        .alert_n   (alert_n)
    );

    p_alert_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> status);

    p_mask_holds_alert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask) |-> alert_n);
endmodule

// File: tb/tmon_top_bench.sv
module tmon_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       throttle_n = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] limit = 8'hFF;
    logic       mask = 1'b0;
    logic       rd_timer = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] timer_q;
    logic       status;
    logic       alert_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmon_top u_tmon_top (
        .clk(clk), .rst_n(rst_n), .throttle_n(throttle_n), .tick(tick),
        .limit(limit), .mask(mask), .rd_timer(rd_timer), .rd_status(rd_status),
        .timer_q(timer_q), .status(status), .alert_n(alert_n)
    );

    // Behavioural reference model
    bit pq[$];
    int m_cnt = 0;
    bit m_stat = 0;
    bit m_alert_n = 1;
    bit m_prev = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            pq = '{1'b1, 1'b1};
            m_cnt = 0; m_stat = 0; m_alert_n = 1; m_prev = 1;
        end else begin
            bit lvl, low, fall, over;
            lvl = pq[0];
            void'(pq.pop_front());
            pq.push_back(throttle_n);
            low  = (lvl == 1'b0);
            fall = m_prev && low;
            over = (m_cnt > int'(limit));
            if (rd_timer)                   m_cnt = low ? 1 : 0;
            else if (fall && m_cnt == 0)    m_cnt = 1;
            else if (tick && low && m_cnt < 255) m_cnt = m_cnt + 1;
            if (rd_timer)       m_stat = 0;
            else if (over)      m_stat = 1;
            else if (rd_status) m_stat = 0;
            m_alert_n = !(m_stat && !mask);
            m_prev = lvl;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(timer_q), m_cnt, "R2/R3/R5/R6 model timer");
            chk(int'(status), int'(m_stat), "R7/R9 model status");
            chk(int'(alert_n), int'(m_alert_n), "R8 model alert");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1); tick = 1'b0;
        end
    endtask

    task automatic read_timer();
        rd_timer = 1'b1; step(1); rd_timer = 1'b0;
    endtask

    initial begin
        step(3);
        chk(int'(timer_q), 0, "R1 reset timer");
        chk(int'(status), 0, "R1 reset status");
        chk(int'(alert_n), 1, "R1 reset alert");
        rst_n = 1'b1;
        step(2);

        throttle_n = 1'b0; step(2);
        chk(int'(timer_q), 0, "R2 not before third edge");
        step(1);
        chk(int'(timer_q), 1, "R2 first edge unit");
        pulse_tick(3);
        chk(int'(timer_q), 4, "R3 low ticks");
        throttle_n = 1'b1; step(3);
        pulse_tick(3);
        chk(int'(timer_q), 4, "R3 high ticks ignored");
        throttle_n = 1'b0; step(4);
        chk(int'(timer_q), 4, "R2 edge on nonzero adds nothing");
        pulse_tick(1);
        chk(int'(timer_q), 5, "R3 reads 00000101");

        rd_timer = 1'b1;
        chk(int'(timer_q), 5, "R4 value visible in strobe cycle");
        step(1); rd_timer = 1'b0;
        chk(int'(timer_q), 1, "R5 reload to one while low");
        pulse_tick(1);
        chk(int'(timer_q), 2, "R5 counts from one");
        throttle_n = 1'b1; step(3);
        read_timer();
        chk(int'(timer_q), 0, "R4 clear while high");
        chk(int'(status), 0, "R4 status clear");

        throttle_n = 1'b0; step(3);
        tick = 1'b1; step(300); tick = 1'b0;
        chk(int'(timer_q), 255, "R6 saturation");
        pulse_tick(2);
        chk(int'(timer_q), 255, "R6 no wrap");
        throttle_n = 1'b1; step(3);
        read_timer();

        limit = 8'h00;
        throttle_n = 1'b0; step(3);
        chk(int'(timer_q), 1, "R7 first assertion count");
        step(1);
        chk(int'(status), 1, "R7 limit zero trips");
        chk(int'(alert_n), 0, "R8 alert active");
        mask = 1'b1; step(1);
        chk(int'(alert_n), 1, "R8 mask holds alert");
        chk(int'(status), 1, "R8 status still set");
        mask = 1'b0; step(1);
        chk(int'(alert_n), 0, "R8 alert returns");
        rd_status = 1'b1; step(1); rd_status = 1'b0;
        chk(int'(status), 1, "R9 read while over keeps flag");
        read_timer();
        chk(int'(status), 0, "R10 cleared by timer read");
        step(1);
        chk(int'(status), 1, "R10 set again");

        throttle_n = 1'b1; step(3);
        read_timer();
        limit = 8'h01;
        throttle_n = 1'b0; step(4);
        chk(int'(timer_q), 1, "R7 count one");
        chk(int'(status), 0, "R7 equal does not trip");
        pulse_tick(1);
        chk(int'(timer_q), 2, "R7 count two");
        step(1);
        chk(int'(status), 1, "R7 limit one trips at two");
        throttle_n = 1'b1; step(3);
        limit = 8'h10; step(1);
        rd_status = 1'b1; step(1); rd_status = 1'b0;
        chk(int'(status), 0, "R9 read clears when under");

        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 15) == 0) throttle_n = ~throttle_n;
            tick      = ($urandom_range(0, 3) == 0);
            rd_timer  = ($urandom_range(0, 39) == 0);
            rd_status = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 99) == 0) limit = 8'($urandom_range(0, 12));
            if ($urandom_range(0, 49) == 0) mask = ~mask;
            step(1);
        end
        tick = 1'b0; rd_timer = 1'b0; rd_status = 1'b0;
        step(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule